// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads page table entries from memory, one entry per level, over a tree of two levels. A requester offers an address together with the kind of access (read, write or instruction fetch) and the privilege of the access. The walker takes one request at a time and holds it until the response is returned.

The first-level entry can point to a second-level table. It can also stop the walk at once and map a 4 MiB region. Every entry on the path is checked for presence, user access and write permission. The first entry that forbids the access ends the walk with a fault code.

When a walk succeeds, the walker writes back the usage bits that changed, through the same memory port it reads from. A control input bypasses translation completely.

Top module: `xlat_walker`

## Requirements
- R1: The first-level index is vaddr[31:22] and the second-level index is vaddr[21:12]. An entry is read from the table base plus four times the index. The first-level base is `root_base`. The second-level base is bits 31:12 of the first-level entry, with bits 11:0 set to zero.
- R2: A walk that succeeds through two levels returns {second-level entry[31:12], vaddr[11:0]}.
- R3: A present first-level entry with bit 7 set is final. The walk reads no second-level entry and returns {entry[31:22], vaddr[21:0]}.
- R4: An entry on the path with bit 0 clear ends the walk with fault code 1. No further entry is read.
- R5: An entry with bit 2 clear faults with code 2 when `req_user`=1. An entry with bit 1 clear faults with code 3 when `req_kind`=2'b01 (write). Reads (2'b00) and fetches (2'b10) never raise code 3. The checks run on the first-level entry first. Code 1 has priority over code 2, and code 2 over code 3.
- R6: `rsp_cacheable` is the inverse of bit 4 of the final entry. A fault returns a physical address of 0 and `rsp_cacheable`=0.
- R7: With `xlat_en`=0 at acceptance, the response returns vaddr unchanged, fault code 0 and `rsp_cacheable`=1, and no memory access takes place.
- R8: A successful walk writes each entry used with bit 5 (accessed) set. On a write access, the final entry is also written with bit 6 (dirty) set. A write is issued only when the value changes. The first-level write comes before the second-level write. A faulting walk writes nothing.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high only while no walk is active. The response stays stable until `rsp_ready`. A memory request keeps its address, direction and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled at acceptance |
| root_base | input | 32 | Base address of the first-level table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 privilege, 3 read-only |
| rsp_cacheable | output | 1 | Target may be cached |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | One-cycle acknowledge, carries read data |
| mem_rdata | input | 32 | Entry read data |

## Verification
The assertions assume that `mem_ack` is a single-cycle pulse that comes only while `mem_req` is high. They also assume that `root_base` and the table contents stay fixed while a walk is running. The stimulus keeps to these rules in three ways. The bench memory raises the acknowledge for exactly one cycle after zero to three wait cycles. It changes `xlat_en` only while no request is pending. It writes table contents only before the first request. Responses are sometimes held off for several cycles so that the rule that a response must stay stable is actually tested.

// File: rtl/xw_pkg.sv
package xw_pkg;
   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_FETCH = 2'd2
   } acc_kind_e;

   localparam logic [1:0] FLT_NONE   = 2'd0;
   localparam logic [1:0] FLT_ABSENT = 2'd1;
   localparam logic [1:0] FLT_PRIV   = 2'd2;
   localparam logic [1:0] FLT_RDONLY = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROOT_RD,
      ST_LEAF_RD,
      ST_ROOT_WR,
      ST_LEAF_WR,
      ST_RESP
   } walk_st_e;

   localparam int unsigned BIT_P  = 0;
   localparam int unsigned BIT_W  = 1;
   localparam int unsigned BIT_U  = 2;
   localparam int unsigned BIT_CD = 4;
   localparam int unsigned BIT_A  = 5;
   localparam int unsigned BIT_D  = 6;
   localparam int unsigned BIT_L  = 7;
endpackage

// File: rtl/xw_entry_addr.sv
module xw_entry_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned ESZ_LG = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned PAD_W = ADDR_W - IDX_W - ESZ_LG;
   logic [ADDR_W-1:0] scaled;
   assign scaled = {{PAD_W{1'b0}}, idx, {ESZ_LG{1'b0}}};
   assign addr   = base + scaled;
endmodule

// File: rtl/xw_perm_check.sv
module xw_perm_check
   import xw_pkg::*;
(
   input  logic       present,
   input  logic       writable,
   input  logic       user_ok,
   input  logic       is_write,
   input  logic       is_user,
   output logic [1:0] fault
);
   always_comb begin
      if (!present)                  fault = FLT_ABSENT;
      else if (is_user && !user_ok)  fault = FLT_PRIV;
      else if (is_write && !writable) fault = FLT_RDONLY;
      else                           fault = FLT_NONE;
   end
endmodule

// File: rtl/xw_pte_update.sv
module xw_pte_update
   import xw_pkg::*;
#(
   parameter int unsigned PTE_W = 32
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             set_dirty,
   output logic [PTE_W-1:0] new_pte,
   output logic             changed
);
   always_comb begin
      new_pte = pte;
      new_pte[BIT_A] = 1'b1;
      if (set_dirty) new_pte[BIT_D] = 1'b1;
   end
   assign changed = (new_pte != pte);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned IDX_W    = 10,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        xlat_en,
   input  logic [31:0] root_base,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_vaddr,
   input  logic [1:0]  req_kind,
   input  logic        req_user,
   output logic        rsp_valid,
   input  logic        rsp_ready,
   output logic [31:0] rsp_paddr,
   output logic [1:0]  rsp_fault,
   output logic        rsp_cacheable,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata
);
   localparam int unsigned PTE_W  = ADDR_W;
   localparam int unsigned ESZ_LG = 2;
   localparam int unsigned LOFF_W = OFF_W + IDX_W;

   if (OFF_W + 2 * IDX_W != ADDR_W) begin : g_bad_split
      $error("address split does not cover the address width");
   end
   if (OFF_W <= BIT_L) begin : g_bad_off
      $error("offset too narrow for entry flag bits");
   end
   if (ADDR_W != 32) begin : g_bad_width
      $error("port width fixed at 32 bits");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q, root_q, leaf_q, pa_q;
   logic              wr_q, user_q, large_q, cach_q;
   logic [1:0]        flt_q;

   logic [IDX_W-1:0]  ridx, lidx;
   logic [ADDR_W-1:0] leaf_base, root_addr, leaf_addr;
   logic              in_large;
   logic [1:0]        in_flt;
   logic [PTE_W-1:0]  in_new, root_new, leaf_new;
   logic              in_chg, root_chg, leaf_chg, in_dirty;
   logic [ADDR_W-1:0] pa_large, pa_small;

   assign ridx      = va_q[ADDR_W-1 -: IDX_W];
   assign lidx      = va_q[OFF_W +: IDX_W];
   assign leaf_base = {root_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   xw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ESZ_LG(ESZ_LG)) u_root_ea (
      .base(root_base), .idx(ridx), .addr(root_addr));
   xw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ESZ_LG(ESZ_LG)) u_leaf_ea (
      .base(leaf_base), .idx(lidx), .addr(leaf_addr));

   if (LARGE_EN) begin : g_large
      assign in_large = mem_rdata[BIT_L];
   end else begin : g_no_large
      assign in_large = 1'b0;
   end

   xw_perm_check u_perm (
      .present (mem_rdata[BIT_P]),
      .writable(mem_rdata[BIT_W]),
      .user_ok (mem_rdata[BIT_U]),
      .is_write(wr_q),
      .is_user (user_q),
      .fault   (in_flt));

   assign in_dirty = wr_q && ((st_q == ST_LEAF_RD) || in_large);

   xw_pte_update #(.PTE_W(PTE_W)) u_upd_in (
      .pte(mem_rdata), .set_dirty(in_dirty), .new_pte(in_new), .changed(in_chg));
   xw_pte_update #(.PTE_W(PTE_W)) u_upd_root (
      .pte(root_q), .set_dirty(wr_q && large_q), .new_pte(root_new), .changed(root_chg));
   xw_pte_update #(.PTE_W(PTE_W)) u_upd_leaf (
      .pte(leaf_q), .set_dirty(wr_q), .new_pte(leaf_new), .changed(leaf_chg));

   assign pa_large = {mem_rdata[ADDR_W-1:LOFF_W], va_q[LOFF_W-1:0]};
   assign pa_small = {mem_rdata[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};

   always_comb begin
      req_ready = (st_q == ST_IDLE);
      rsp_valid = (st_q == ST_RESP);
      mem_req   = (st_q == ST_ROOT_RD) || (st_q == ST_LEAF_RD) ||
                  (st_q == ST_ROOT_WR) || (st_q == ST_LEAF_WR);
      mem_we    = (st_q == ST_ROOT_WR) || (st_q == ST_LEAF_WR);
      mem_addr  = ((st_q == ST_ROOT_RD) || (st_q == ST_ROOT_WR)) ? root_addr : leaf_addr;
      mem_wdata = (st_q == ST_ROOT_WR) ? root_new : leaf_new;
   end

   assign rsp_paddr     = pa_q;
   assign rsp_fault     = flt_q;
   assign rsp_cacheable = cach_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         root_q  <= '0;
         leaf_q  <= '0;
         pa_q    <= '0;
         wr_q    <= 1'b0;
         user_q  <= 1'b0;
         large_q <= 1'b0;
         cach_q  <= 1'b0;
         flt_q   <= FLT_NONE;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= (req_kind == KIND_WRITE);
               user_q  <= req_user;
               large_q <= 1'b0;
               if (!xlat_en) begin
                  pa_q   <= req_vaddr;
                  flt_q  <= FLT_NONE;
                  cach_q <= 1'b1;
                  st_q   <= ST_RESP;
               end else begin
                  st_q   <= ST_ROOT_RD;
               end
            end
            ST_ROOT_RD: if (mem_ack) begin
               root_q  <= mem_rdata;
               large_q <= in_large;
               if (in_flt != FLT_NONE) begin
                  pa_q   <= '0;
                  cach_q <= 1'b0;
                  flt_q  <= in_flt;
                  st_q   <= ST_RESP;
               end else if (in_large) begin
                  pa_q   <= pa_large;
                  cach_q <= !mem_rdata[BIT_CD];
                  flt_q  <= FLT_NONE;
                  st_q   <= in_chg ? ST_ROOT_WR : ST_RESP;
               end else begin
                  st_q   <= ST_LEAF_RD;
               end
            end
            ST_LEAF_RD: if (mem_ack) begin
               leaf_q <= mem_rdata;
               if (in_flt != FLT_NONE) begin
                  pa_q   <= '0;
                  cach_q <= 1'b0;
                  flt_q  <= in_flt;
                  st_q   <= ST_RESP;
               end else begin
                  pa_q   <= pa_small;
                  cach_q <= !mem_rdata[BIT_CD];
                  flt_q  <= FLT_NONE;
                  if (root_chg)    st_q <= ST_ROOT_WR;
                  else if (in_chg) st_q <= ST_LEAF_WR;
                  else             st_q <= ST_RESP;
               end
            end
            ST_ROOT_WR: if (mem_ack) begin
               st_q <= (!large_q && leaf_chg) ? ST_LEAF_WR : ST_RESP;
            end
            ST_LEAF_WR: if (mem_ack) begin
               st_q <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
   parameter int unsigned OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [OFF_W-1:0] req_vlo,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [31:0]      rsp_paddr,
   input logic [1:0]       rsp_fault,
   input logic             rsp_cacheable,
   input logic             mem_req,
   input logic             mem_we,
   input logic [31:0]      mem_addr,
   input logic [31:0]      mem_wdata,
   input logic             mem_ack
);
   logic [OFF_W-1:0] off_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                      off_q <= '0;
      else if (req_valid && req_ready) off_q <= req_vlo;
   end

   assert_memhold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_rsphold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cacheable));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !mem_req);

   assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

   assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0) && !rsp_cacheable);

   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_q);
endmodule

bind xlat_walker xw_checker #(.OFF_W(OFF_W)) u_xw_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vlo(req_vaddr[OFF_W-1:0]), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cacheable(rsp_cacheable),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack));

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_en = 1'b1;
   logic [31:0] root_base = 32'h0001_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        rsp_cacheable;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #10 clk = ~clk;

   xlat_walker u_xlat_walker (.*);

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [31:0] dut_mem [int unsigned];
   logic [31:0] ref_mem [int unsigned];
   logic [63:0] exp_wr [$];
   int rd_cnt = 0;
   int unsigned wait_ctr = 1;
   int unsigned wseq = 0;
   logic [31:0] got_pa;
   logic [1:0]  got_flt;
   logic        got_cach;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: one-cycle ack after 0..3 wait cycles
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wseq++;
         wait_ctr = wseq % 4;
      end else if (mem_req && rst_n) begin
         if (wait_ctr == 0) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               if (exp_wr.size() == 0) begin
                  chk(1'b0, "R8 unexpected write", mem_addr, 32'h0);
               end else begin
                  logic [63:0] e;
                  e = exp_wr.pop_front();
                  chk(e[63:32] == mem_addr, "R8 write address", mem_addr, e[63:32]);
                  chk(e[31:0] == mem_wdata, "R8 write data", mem_wdata, e[31:0]);
               end
               dut_mem[mem_addr] = mem_wdata;
            end else begin
               rd_cnt++;
               mem_rdata = dut_mem.exists(mem_addr) ? dut_mem[mem_addr] : 32'h0;
            end
         end else begin
            wait_ctr--;
         end
      end
   end

   // every-clock comparison: idle walker has nothing in flight (R9)
   always @(negedge clk) begin
      if (rst_n && !finished && req_ready)
         chk(!mem_req && !rsp_valid, "R9 idle quiet", {30'd0, mem_req, rsp_valid}, 32'h0);
   end

   function automatic logic [1:0] ref_perm(logic [31:0] e, bit wr, bit usr);
      if (!e[0])           return 2'd1;
      if (usr && !e[2])    return 2'd2;
      if (wr && !e[1])     return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] rd_ref(logic [31:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
   endfunction

   task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind, input bit usr, input bit en,
                           output logic [31:0] pa, output logic [1:0] flt, output bit cach, output int nrd);
      logic [31:0] ra, la, re, le, nv;
      bit wr;
      wr = (kind == 2'b01);
      pa = 0; flt = 0; cach = 0; nrd = 0;
      if (!en) begin pa = va; cach = 1; return; end
      ra = root_base + {va[31:22], 2'b00};
      re = rd_ref(ra); nrd = 1;
      flt = ref_perm(re, wr, usr);
      if (flt != 0) return;
      if (re[7]) begin
         pa = {re[31:22], va[21:0]};
         cach = !re[4];
         nv = re | 32'h20 | (wr ? 32'h40 : 32'h0);
         if (nv != re) begin exp_wr.push_back({ra, nv}); ref_mem[ra] = nv; end
         return;
      end
      la = {re[31:12], 12'h0} + {va[21:12], 2'b00};
      le = rd_ref(la); nrd = 2;
      flt = ref_perm(le, wr, usr);
      if (flt != 0) return;
      pa = {le[31:12], va[11:0]};
      cach = !le[4];
      nv = re | 32'h20;
      if (nv != re) begin exp_wr.push_back({ra, nv}); ref_mem[ra] = nv; end
      nv = le | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (nv != le) begin exp_wr.push_back({la, nv}); ref_mem[la] = nv; end
   endtask

   task automatic run(input logic [31:0] va, input logic [1:0] kind, input bit usr, input bit en,
                      input int stall, input string tag);
      logic [31:0] epa; logic [1:0] eflt; bit ecach; int enrd;
      ref_walk(va, kind, usr, en, epa, eflt, ecach, enrd);
      rd_cnt = 0;
      @(negedge clk);
      xlat_en = en; req_vaddr = va; req_kind = kind; req_user = usr; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      got_pa = rsp_paddr; got_flt = rsp_fault; got_cach = rsp_cacheable;
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_paddr == got_pa && rsp_fault == got_flt, "R9 response held",
             rsp_paddr, got_pa);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(got_pa == epa, {tag, " paddr"}, got_pa, epa);
      chk(got_flt == eflt, {tag, " fault"}, {30'd0, got_flt}, {30'd0, eflt});
      chk(got_cach == ecach, "R6 cacheable", {31'd0, got_cach}, {31'd0, ecach});
      chk(rd_cnt == enrd, {tag, " entry reads"}, rd_cnt, enrd);
      chk(exp_wr.size() == 0, "R8 pending writes", exp_wr.size(), 0);
   endtask

   task automatic load(input logic [31:0] a, input logic [31:0] d);
      dut_mem[a] = d; ref_mem[a] = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      load(32'h0001_0000, 32'h0002_0007);  // root 0 -> table 0x20000
      load(32'h0002_0000, 32'h00AB_0007);  // user rw
      load(32'h0002_0004, 32'h00AB_1005);  // user read-only
      load(32'h0002_0008, 32'h00AB_2003);  // supervisor rw
      load(32'h0002_000C, 32'h00AB_3006);  // absent
      load(32'h0002_0010, 32'h00AB_4077);  // cache-disabled, A/D set
      load(32'h0001_0004, 32'h3000_0087);  // large page
      load(32'h0001_0008, 32'h0000_0000);  // absent root
      load(32'h0001_000C, 32'h0002_1023);  // supervisor root
      load(32'h0002_1000, 32'h00CD_0027);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R9 reset state",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);

      run(32'h1234_5678, 2'b00, 1, 0, 2, "R7 bypass");
      chk(got_pa == 32'h1234_5678, "R7 bypass value", got_pa, 32'h1234_5678);
      run(32'h0000_0123, 2'b00, 1, 1, 0, "R1 R2 first walk");
      chk(got_pa == 32'h00AB_0123, "R2 small page", got_pa, 32'h00AB_0123);
      run(32'h0000_0123, 2'b00, 1, 1, 3, "R8 no change");
      run(32'h0000_0456, 2'b01, 1, 1, 0, "R8 dirty");
      run(32'h0000_1010, 2'b01, 1, 1, 1, "R5 read-only write");
      chk(got_flt == 2'd3, "R5 code 3", {30'd0, got_flt}, 32'd3);
      run(32'h0000_1010, 2'b10, 1, 1, 0, "R5 fetch");
      run(32'h0000_2000, 2'b00, 1, 1, 0, "R5 user on supervisor");
      run(32'h0000_2ABC, 2'b01, 0, 1, 0, "R5 supervisor write");
      run(32'h0000_3000, 2'b00, 0, 1, 0, "R4 absent leaf");
      chk(got_flt == 2'd1, "R4 code 1", {30'd0, got_flt}, 32'd1);
      run(32'h0000_4444, 2'b00, 1, 1, 0, "R6 cache off");
      run(32'h0045_6789, 2'b01, 1, 1, 2, "R3 large");
      chk(got_pa == 32'h3005_6789, "R3 large value", got_pa, 32'h3005_6789);
      run(32'h0080_0000, 2'b00, 0, 1, 0, "R4 absent root");
      run(32'h00C0_0010, 2'b00, 1, 1, 0, "R5 root privilege");
      run(32'h00C0_0010, 2'b00, 0, 1, 0, "R1 supervisor root");
      run(32'h0000_0FFC, 2'b00, 0, 0, 1, "R7 bypass again");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule